// File: doc/BRIEF.md
# Floating-Point Conditional Move Unit

This unit holds a floating-point register file of sixteen 32-bit entries and carries out conditional register-to-register moves on it. Each request names a 4-bit sub-opcode, a destination index r, a source index s and a condition index t. When the sub-opcode's condition holds, the bit pattern of entry s is copied into entry r on the next clock edge. When the condition fails, r keeps its value.

The condition takes one of two forms. It is either a signed test of a 32-bit general-register value against zero, or a test of one bit, selected by t, of a 16-bit boolean register. Sub-opcodes 1 to 7 belong to comparison operations handled elsewhere, so this unit ignores them. Sub-opcodes 0, 14 and 15 are unassigned and produce a one-cycle reserved-instruction pulse.

A plain load port fills entries, and a combinational read port observes them. Both belong to the normal interface of the register file.

Top module: `fcm_unit`

## Requirements
- R1: Sub-opcode 8 copies entry s into entry r only when the general-register value is zero.
- R2: Sub-opcode 9 copies only when the general-register value is nonzero.
- R3: Sub-opcode 10 copies only when the general-register value, read as a signed 32-bit number, is negative (bit 31 set).
- R4: Sub-opcode 11 copies only when the general-register value, read as a signed number, is zero or positive (bit 31 clear).
- R5: Sub-opcode 12 copies only when bit t of the boolean register is 0.
- R6: Sub-opcode 13 copies only when bit t of the boolean register is 1.
- R7: When the condition fails, or when the request strobe is low, every entry keeps its value, and a move never alters any entry other than r.
- R8: The copy is a raw 32-bit pattern move, so NaN payloads and negative zero arrive unchanged.
- R9: A valid request with sub-opcode 0, 14 or 15 raises the reserved output for exactly the cycle after the request edge, and writes nothing.
- R10: A valid request with sub-opcodes 1 to 7 writes nothing and raises no reserved indication.
- R11: A move becomes visible on the read port right after the clock edge that samples the request. The source value used is the one held before that edge, so a move in the next cycle sees the updated entry.
- R12: When the load enable is high, the load data is written to the load index on the next edge. If a move targets the same entry in the same cycle, the load wins.
- R13: After reset every entry reads zero and the reserved output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request strobe |
| req_op | input | 4 | Sub-opcode |
| req_r | input | 4 | Destination entry index |
| req_s | input | 4 | Source entry index |
| req_t | input | 4 | Boolean bit index for sub-opcodes 12 and 13 |
| gpr_val | input | 32 | General-register value tested against zero |
| bool_reg | input | 16 | Boolean register |
| ld_en | input | 1 | Load enable |
| ld_idx | input | 4 | Load entry index |
| ld_data | input | 32 | Load data |
| rd_idx | input | 4 | Read entry index |
| rd_data | output | 32 | Contents of entry rd_idx |
| reserved_o | output | 1 | One-cycle pulse for a reserved sub-opcode |

## Verification
The bench builds the unit with its default parameters: 32-bit entries, sixteen entries and a 16-bit boolean register. At this size every entry index and every boolean bit can be reached by directed and random stimulus. This covers the sign-bit boundary at 0x80000000 and 0x7FFFFFFF, and moves where source and destination are the same entry. It also covers back-to-back dependent moves and collisions between a load and a move on one entry. After every edge the full file is swept through the read port and compared with a behavioural model.

// File: rtl/fcm_pkg.sv
package fcm_pkg;
  localparam logic [3:0] OP_MOV_Z   = 4'd8;
  localparam logic [3:0] OP_MOV_NZ  = 4'd9;
  localparam logic [3:0] OP_MOV_NEG = 4'd10;
  localparam logic [3:0] OP_MOV_NNG = 4'd11;
  localparam logic [3:0] OP_MOV_BF  = 4'd12;
  localparam logic [3:0] OP_MOV_BT  = 4'd13;

  function automatic logic op_is_reserved(input logic [3:0] op);
    return (op == 4'd0) || (op == 4'd14) || (op == 4'd15);
  endfunction
endpackage

// File: rtl/fcm_cond.sv
module fcm_cond #(
  parameter int DATA_W = 32,
  parameter int BOOL_W = 16,
  parameter int TB_W   = 4
) (
  input  logic [3:0]        op_i,
  input  logic [DATA_W-1:0] gval_i,
  input  logic [BOOL_W-1:0] bvec_i,
  input  logic [TB_W-1:0]   t_i,
  output logic              take_o,
  output logic              rsv_o
);
  import fcm_pkg::*;

  logic gz, gneg, bsel;

  always_comb begin
    gz   = (gval_i == '0);
    gneg = gval_i[DATA_W-1];
    bsel = bvec_i[t_i];
    take_o = 1'b0;
    case (op_i)
      OP_MOV_Z:   take_o = gz;
      OP_MOV_NZ:  take_o = !gz;
      OP_MOV_NEG: take_o = gneg;
      OP_MOV_NNG: take_o = !gneg;
      OP_MOV_BF:  take_o = !bsel;
      OP_MOV_BT:  take_o = bsel;
      default:    take_o = 1'b0;
    endcase
    rsv_o = op_is_reserved(op_i);
  end
endmodule

// File: rtl/fcm_regfile.sv
module fcm_regfile #(
  parameter int DATA_W = 32,
  parameter int NREG   = 16,
  parameter int IDX_W  = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mv_we_i,
  input  logic [IDX_W-1:0]  mv_idx_i,
  input  logic [DATA_W-1:0] mv_data_i,
  input  logic              ld_we_i,
  input  logic [IDX_W-1:0]  ld_idx_i,
  input  logic [DATA_W-1:0] ld_data_i,
  input  logic [IDX_W-1:0]  rs_idx_i,
  output logic [DATA_W-1:0] rs_data_o,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [DATA_W-1:0] rd_data_o
);
  logic [DATA_W-1:0] ent_q [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_ent
    logic              en;
    logic [DATA_W-1:0] d;

    always_comb begin
      en = 1'b0;
      d  = ent_q[i];
      if (ld_we_i && (ld_idx_i == IDX_W'(i))) begin
        en = 1'b1;
        d  = ld_data_i;
      end else if (mv_we_i && (mv_idx_i == IDX_W'(i))) begin
        en = 1'b1;
        d  = mv_data_i;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  ent_q[i] <= '0;
      else if (en) ent_q[i] <= d;
    end

    // R7: an entry named by neither write port holds its value
    a_r7_entry_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !((ld_we_i && ld_idx_i == IDX_W'(i)) || (mv_we_i && mv_idx_i == IDX_W'(i)))
      |=> $stable(ent_q[i]));

    // R12: a load on this entry lands on the next edge, ahead of any move
    a_r12_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_we_i && ld_idx_i == IDX_W'(i)) |=> (ent_q[i] == $past(ld_data_i)));
  end

  assign rs_data_o = ent_q[rs_idx_i];
  assign rd_data_o = ent_q[rd_idx_i];
endmodule

// File: rtl/fcm_unit.sv
module fcm_unit #(
  parameter int DATA_W = 32,
  parameter int NREG   = 16,
  parameter int BOOL_W = 16,
  localparam int IDX_W = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [3:0]        req_op,
  input  logic [IDX_W-1:0]  req_r,
  input  logic [IDX_W-1:0]  req_s,
  input  logic [IDX_W-1:0]  req_t,
  input  logic [DATA_W-1:0] gpr_val,
  input  logic [BOOL_W-1:0] bool_reg,
  input  logic              ld_en,
  input  logic [IDX_W-1:0]  ld_idx,
  input  logic [DATA_W-1:0] ld_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data,
  output logic              reserved_o
);
  logic [1:0]        rst_sync_q;
  logic              srst_n;
  logic              take, rsv_dec;
  logic              mv_we;
  logic [DATA_W-1:0] src_data;
  logic              rsv_d, rsv_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign srst_n = rst_sync_q[1];

  fcm_cond #(.DATA_W(DATA_W), .BOOL_W(BOOL_W), .TB_W(IDX_W)) u_cond (
    .op_i   (req_op),
    .gval_i (gpr_val),
    .bvec_i (bool_reg),
    .t_i    (req_t),
    .take_o (take),
    .rsv_o  (rsv_dec)
  );

  assign mv_we = req_valid && take;

  fcm_regfile #(.DATA_W(DATA_W), .NREG(NREG), .IDX_W(IDX_W)) u_rf (
    .clk       (clk),
    .rst_n     (srst_n),
    .mv_we_i   (mv_we),
    .mv_idx_i  (req_r),
    .mv_data_i (src_data),
    .ld_we_i   (ld_en),
    .ld_idx_i  (ld_idx),
    .ld_data_i (ld_data),
    .rs_idx_i  (req_s),
    .rs_data_o (src_data),
    .rd_idx_i  (rd_idx),
    .rd_data_o (rd_data)
  );

  always_comb rsv_d = req_valid && rsv_dec;

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) rsv_q <= 1'b0;
    else         rsv_q <= rsv_d;
  end
  assign reserved_o = rsv_q;

  // R9: a reserved pulse follows only a valid request with opcode 0, 14 or 15
  a_r9_rsv_source: assert property (@(posedge clk) disable iff (!srst_n)
    reserved_o |-> $past(req_valid) &&
      ($past(req_op) == 4'd0 || $past(req_op) == 4'd14 || $past(req_op) == 4'd15));

  // R9: reserved opcodes never enable a move
  a_r9_rsv_no_write: assert property (@(posedge clk) disable iff (!srst_n)
    (req_op == 4'd0 || req_op >= 4'd14) |-> !mv_we);

  // R10: the comparison opcodes neither move nor flag reserved
  a_r10_cmp_quiet: assert property (@(posedge clk) disable iff (!srst_n)
    (req_valid && req_op >= 4'd1 && req_op <= 4'd7) |=> !reserved_o);

  // R5: move-if-false is blocked by a set boolean bit
  a_r5_bf_block: assert property (@(posedge clk) disable iff (!srst_n)
    (req_op == 4'd12 && bool_reg[req_t]) |-> !mv_we);

  // R6: move-if-true is blocked by a clear boolean bit
  a_r6_bt_block: assert property (@(posedge clk) disable iff (!srst_n)
    (req_op == 4'd13 && !bool_reg[req_t]) |-> !mv_we);

  // R3: a non-negative value never passes the negative test
  a_r3_neg_block: assert property (@(posedge clk) disable iff (!srst_n)
    (req_op == 4'd10 && !gpr_val[DATA_W-1]) |-> !mv_we);

  // R7: no strobe, no move
  a_r7_idle: assert property (@(posedge clk) disable iff (!srst_n)
    !req_valid |-> !mv_we);
endmodule

// File: tb/fcm_unit_bench.sv
`timescale 1ns/10ps
module fcm_unit_bench;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic [3:0]  req_op, req_r, req_s, req_t;
  logic [31:0] gpr_val;
  logic [15:0] bool_reg;
  logic        ld_en;
  logic [3:0]  ld_idx;
  logic [31:0] ld_data;
  logic [3:0]  rd_idx;
  logic [31:0] rd_data;
  logic        reserved_o;

  int total = 0;
  int bad = 0;
  bit done = 0;
  logic [31:0] model [16];
  logic        model_rsv;

  always #(PERIOD/2) clk = ~clk;

  fcm_unit u_fcm_unit (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_r(req_r), .req_s(req_s), .req_t(req_t), .gpr_val(gpr_val),
    .bool_reg(bool_reg), .ld_en(ld_en), .ld_idx(ld_idx), .ld_data(ld_data),
    .rd_idx(rd_idx), .rd_data(rd_data), .reserved_o(reserved_o)
  );

  function automatic bit cond_holds(input logic [3:0] op, input logic [31:0] g,
                                    input logic [15:0] b, input logic [3:0] t);
    case (op)
      4'd8:  return g == 32'd0;
      4'd9:  return g != 32'd0;
      4'd10: return $signed(g) < 0;
      4'd11: return $signed(g) >= 0;
      4'd12: return b[t] == 1'b0;
      4'd13: return b[t] == 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  task automatic check_all(input string tag);
    for (int i = 0; i < 16; i++) begin
      rd_idx = 4'(i);
      #0.1;
      total++;
      if (rd_data !== model[i]) begin
        bad++;
        $display("FAIL %s entry %0d actual=%h expected=%h", tag, i, rd_data, model[i]);
      end
    end
    total++;
    if (reserved_o !== model_rsv) begin
      bad++;
      $display("FAIL %s reserved actual=%b expected=%b", tag, reserved_o, model_rsv);
    end
  endtask

  task automatic step(input string tag, input bit v, input logic [3:0] op,
                      input logic [3:0] r, input logic [3:0] s, input logic [3:0] t,
                      input logic [31:0] g, input logic [15:0] b,
                      input bit le, input logic [3:0] li, input logic [31:0] ldv);
    logic [31:0] src;
    req_valid = v; req_op = op; req_r = r; req_s = s; req_t = t;
    gpr_val = g; bool_reg = b; ld_en = le; ld_idx = li; ld_data = ldv;
    src = model[s];
    if (v && cond_holds(op, g, b, t)) model[r] = src;
    if (le) model[li] = ldv;
    model_rsv = v && (op == 4'd0 || op == 4'd14 || op == 4'd15);
    @(negedge clk);
    check_all(tag);
  endtask

  task automatic load(input logic [3:0] i, input logic [31:0] d);
    step("R12", 0, 4'd8, 0, 0, 0, 0, 0, 1, i, d);
  endtask

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req_valid = 0; req_op = 0; req_r = 0; req_s = 0; req_t = 0;
    gpr_val = 0; bool_reg = 0; ld_en = 0; ld_idx = 0; ld_data = 0; rd_idx = 0;
    for (int i = 0; i < 16; i++) model[i] = 32'd0;
    model_rsv = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check_all("R13");

    for (int i = 0; i < 16; i++) load(4'(i), 32'h1000_0000 + 32'(i) * 32'h0101_0101);

    // R1
    step("R1", 1, 4'd8, 4'd2, 4'd5, 0, 32'd0, 0, 0, 0, 0);
    step("R1", 1, 4'd8, 4'd3, 4'd6, 0, 32'd1, 0, 0, 0, 0);
    // R2
    step("R2", 1, 4'd9, 4'd4, 4'd7, 0, 32'hFFFF_FFFF, 0, 0, 0, 0);
    step("R2", 1, 4'd9, 4'd4, 4'd8, 0, 32'd0, 0, 0, 0, 0);
    // R3 sign boundary
    step("R3", 1, 4'd10, 4'd0, 4'd9, 0, 32'h8000_0000, 0, 0, 0, 0);
    step("R3", 1, 4'd10, 4'd1, 4'd9, 0, 32'h7FFF_FFFF, 0, 0, 0, 0);
    step("R3", 1, 4'd10, 4'd1, 4'd9, 0, 32'd0, 0, 0, 0, 0);
    // R4
    step("R4", 1, 4'd11, 4'd10, 4'd11, 0, 32'd0, 0, 0, 0, 0);
    step("R4", 1, 4'd11, 4'd12, 4'd11, 0, 32'h8000_0001, 0, 0, 0, 0);
    step("R4", 1, 4'd11, 4'd12, 4'd13, 0, 32'h7FFF_FFFF, 0, 0, 0, 0);
    // R5 / R6 on high and low boolean bits
    step("R5", 1, 4'd12, 4'd14, 4'd1, 4'd15, 0, 16'h7FFF, 0, 0, 0);
    step("R5", 1, 4'd12, 4'd15, 4'd1, 4'd3, 0, 16'h0008, 0, 0, 0);
    step("R6", 1, 4'd13, 4'd15, 4'd2, 4'd0, 0, 16'h0001, 0, 0, 0);
    step("R6", 1, 4'd13, 4'd5, 4'd2, 4'd7, 0, 16'hFF7F, 0, 0, 0);
    // R7: strobe low with a passing condition
    step("R7", 0, 4'd8, 4'd6, 4'd0, 0, 32'd0, 0, 0, 0, 0);
    // R8: NaN payload and negative zero
    load(4'd7, 32'h7FC1_2345);
    step("R8", 1, 4'd9, 4'd8, 4'd7, 0, 32'd3, 0, 0, 0, 0);
    load(4'd7, 32'h8000_0000);
    step("R8", 1, 4'd11, 4'd9, 4'd7, 0, 32'd3, 0, 0, 0, 0);
    load(4'd7, 32'hFF80_0001);
    step("R8", 1, 4'd13, 4'd10, 4'd7, 4'd4, 0, 16'h0010, 0, 0, 0);
    // R9 reserved opcodes, including back-to-back
    step("R9", 1, 4'd0, 4'd1, 4'd2, 0, 32'd0, 16'hFFFF, 0, 0, 0);
    step("R9", 1, 4'd14, 4'd1, 4'd2, 0, 32'd0, 16'hFFFF, 0, 0, 0);
    step("R9", 1, 4'd15, 4'd1, 4'd2, 0, 32'd0, 16'hFFFF, 0, 0, 0);
    step("R9", 0, 4'd15, 4'd1, 4'd2, 0, 32'd0, 16'hFFFF, 0, 0, 0);
    // R10 comparison opcodes
    for (int op = 1; op <= 7; op++)
      step("R10", 1, 4'(op), 4'd3, 4'd4, 0, 32'd0, 16'hFFFF, 0, 0, 0);
    // R11 dependent moves and s == r
    load(4'd1, 32'hCAFE_0001);
    step("R11", 1, 4'd8, 4'd2, 4'd1, 0, 32'd0, 0, 0, 0, 0);
    step("R11", 1, 4'd8, 4'd3, 4'd2, 0, 32'd0, 0, 0, 0, 0);
    step("R11", 1, 4'd9, 4'd3, 4'd3, 0, 32'd9, 0, 0, 0, 0);
    // R11: load to source and move in same cycle uses old source
    step("R11", 1, 4'd8, 4'd4, 4'd1, 0, 32'd0, 0, 1, 4'd1, 32'hBEEF_0002);
    // R12: load and move on one entry, load wins
    step("R12", 1, 4'd8, 4'd6, 4'd1, 0, 32'd0, 0, 1, 4'd6, 32'h1234_5678);

    // random traffic
    for (int n = 0; n < 400; n++) begin
      logic [3:0] op;
      op = 4'($urandom_range(0, 15));
      step($sformatf("R%0d", (op >= 8 && op <= 13) ? op - 7 : (op == 0 || op >= 14) ? 9 : 10),
           1'($urandom_range(0, 3) != 0), op, 4'($urandom), 4'($urandom), 4'($urandom),
           ($urandom_range(0, 3) == 0) ? 32'd0 : $urandom, 16'($urandom),
           1'($urandom_range(0, 4) == 0), 4'($urandom), $urandom);
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule